// File: doc/BRIEF.md
# Mixed-Edge Scan Shift Chain

This block is a scan shift chain whose cells may each be clocked on either edge of the scan clock. A parameter vector gives every cell its edge. One scan-enable input chooses between shifting (each cell takes the value of its upstream neighbour, with cell 0 taking the serial input) and functional capture (each cell takes its own bit of the parallel data input). The last cell drives the serial output, and the whole cell vector is brought out as the captured register vector.

Where a rising-edge cell feeds a falling-edge cell, the block builds a lock-up stage into the link. The stage shows the downstream cell the upstream value from the previous low phase, not the one just launched, so no bit crosses two cells in one clock period. A falling-edge cell feeding a rising-edge cell, and any link between cells on the same edge, are wired directly.

At elaboration the block reports every link where a lock-up stage was built. If strict ordering is enabled, it also rejects chains that break the preferred edge order for the chosen clock style: falling before rising for a return-to-zero clock, and the reverse otherwise.

Top module: `mixed_edge_scan_chain`

## Requirements
- R1: Bit i of the polarity parameter sets the edge of cell i (1 = rising, 0 = falling). Cell 0 takes the serial input, and cell N-1 drives scanOut and is bit N-1 of capQ.
- R2: With scanEn = 1, every cell takes the value its upstream link offers once per clock period, on its own edge. A value therefore advances exactly one cell per period.
- R3: With scanEn = 0, cell i takes dataIn[i] on its own edge and scanIn has no effect. One full period after dataIn is applied, capQ equals dataIn and scanOut equals dataIn[N-1].
- R4: While rstN is low, every cell and every lock-up stage holds 0, so capQ = 0 and scanOut = 0. The clear is asynchronous.
- R5: At a rising-to-falling link, the downstream falling-edge cell takes, on its falling edge, the value the upstream cell held at the previous falling edge. This adds one half period to that link (three half periods in total).
- R6: At a falling-to-rising link there is no lock-up stage. The downstream rising-edge cell takes the upstream value on the next rising edge, so the link costs one half period.
- R7: Apply scanIn a quarter period after a rising edge and sample outputs three quarters of a period later. Cell j then shows the scanIn bit from ceil(Dj/2) periods earlier. Dj counts half periods: 2 for a rising cell 0 or 1 for a falling cell 0, then for each link up to j add 2 (same edge), 1 (falling to rising) or 3 (rising to falling).
- R8: A chain whose cells are all rising or all falling delivers scanIn at scanOut exactly N periods later and has no lock-up stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan clock; cells use either edge |
| rstN | input | 1 | Asynchronous clear, active low |
| scanEn | input | 1 | 1 = shift, 0 = functional capture |
| scanIn | input | 1 | Serial input to cell 0 |
| dataIn | input | N | Functional capture data, bit i to cell i |
| scanOut | output | 1 | Serial output, value of cell N-1 |
| capQ | output | N | Current contents of all cells |

## Verification
The same pseudo-random serial stream is shifted through five chains at once: all rising, all falling, falling then rising, rising then falling, and alternating edges. Every cell is compared each period against the stream delayed by its own half-period count. The uniform chains pin the plain N-period latency. The falling-then-rising chain shows that the direct link saves a half period. The rising-then-falling and alternating chains expose a missing or misplaced lock-up stage as a one-period shortfall at scanOut. Two parallel loads with scanIn held opposite separate functional capture from shifting, and resets before and during the shift show the asynchronous clear on every chain.

// File: rtl/msc_pkg.sv
package msc_pkg;

  // Clock waveform style used to judge the preferred edge order.
  typedef enum logic {
    CLK_RTZ = 1'b0,
    CLK_NRZ = 1'b1
  } clkStyleT;

  // Strobes from control to the cells.
  typedef struct packed {
    logic shift;
    logic load;
  } strobeT;

endpackage

// File: rtl/msc_ctrl.sv
module msc_ctrl
  import msc_pkg::*;
#(
  parameter int                N            = 8,
  parameter logic [N-1:0]      POLARITY     = '1,
  parameter msc_pkg::clkStyleT CLK_STYLE    = msc_pkg::CLK_RTZ,
  parameter bit                STRICT_ORDER = 1'b0
) (
  input  logic   scanEn,
  output strobeT strobe
);

  always_comb begin
    strobe.shift = scanEn;
    strobe.load  = !scanEn;
  end

  // Elaboration-time report of lock-up links and optional order rejection.
  for (genvar gi = 0; gi < N - 1; gi++) begin : g_order
    localparam bit RISE_FALL = POLARITY[gi] && !POLARITY[gi+1];
    localparam bit FALL_RISE = !POLARITY[gi] && POLARITY[gi+1];
    localparam bit OFF_ORDER = (CLK_STYLE == CLK_RTZ) ? RISE_FALL : FALL_RISE;
    if (RISE_FALL) begin : g_note
      initial $display("msc: lock-up stage on link cell %0d -> cell %0d", gi, gi + 1);
    end
    if (STRICT_ORDER && OFF_ORDER) begin : g_reject
      initial $fatal(1, "msc: link cell %0d -> cell %0d breaks preferred edge order", gi, gi + 1);
    end
  end

endmodule

// File: rtl/msc_cell.sv
module msc_cell
  import msc_pkg::*;
#(
  parameter bit RISE = 1'b1
) (
  input  logic   clk,
  input  logic   rstN,
  input  strobeT strobe,
  input  logic   shiftD,
  input  logic   loadD,
  output logic   q
);

  logic nextD;

  always_comb begin
    if (strobe.shift)     nextD = shiftD;
    else if (strobe.load) nextD = loadD;
    else                  nextD = q;
  end

  if (RISE) begin : g_rise
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= 1'b0;
      else       q <= nextD;
    end
    AST_RISE_FUNC_LOAD: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.load && !strobe.shift) |=> q == $past(loadD)); // R3
  end else begin : g_fall
    always_ff @(negedge clk or negedge rstN) begin
      if (!rstN) q <= 1'b0;
      else       q <= nextD;
    end
    AST_FALL_FUNC_LOAD: assert property (@(negedge clk) disable iff (!rstN)
      (strobe.load && !strobe.shift) |=> q == $past(loadD)); // R3
  end

endmodule

// File: rtl/msc_lockup.sv
module msc_lockup (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  // Opens on the low phase, holds through the high phase. The upstream
  // rising-edge cell only changes while this stage is closed, so its output
  // is the value present when the low phase begins.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) q <= 1'b0;
    else       q <= d;
  end

endmodule

// File: rtl/msc_datapath.sv
module msc_datapath
  import msc_pkg::*;
#(
  parameter int           N        = 8,
  parameter logic [N-1:0] POLARITY = '1
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobeT       strobe,
  input  logic         scanIn,
  input  logic [N-1:0] dataIn,
  output logic [N-1:0] capQ,
  output logic         scanOut
);

  localparam int LAST = N - 1;

  logic [N-1:0] cellQ;
  logic [N-1:0] feed;   // value offered to each cell while shifting

  assign feed[0] = scanIn;

  for (genvar gi = 0; gi < N; gi++) begin : g_cell
    msc_cell #(.RISE(POLARITY[gi])) u_cell (
      .clk    (clk),
      .rstN   (rstN),
      .strobe (strobe),
      .shiftD (feed[gi]),
      .loadD  (dataIn[gi]),
      .q      (cellQ[gi])
    );
  end

  for (genvar gi = 0; gi < N - 1; gi++) begin : g_link
    localparam bit UP_RISE = POLARITY[gi];
    localparam bit DN_RISE = POLARITY[gi+1];
    if (UP_RISE && !DN_RISE) begin : g_lockup
      logic lockQ;
      msc_lockup u_lockup (
        .clk  (clk),
        .rstN (rstN),
        .d    (cellQ[gi]),
        .q    (lockQ)
      );
      assign feed[gi+1] = lockQ;
      AST_NO_DOUBLE_SHIFT: assert property (@(negedge clk) disable iff (!rstN)
        strobe.shift |=> cellQ[gi+1] == $past(cellQ[gi], 2)); // R5
    end else begin : g_direct
      assign feed[gi+1] = cellQ[gi];
      if (!UP_RISE && DN_RISE) begin : g_fall_rise
        AST_FALL_RISE_LINK: assert property (@(posedge clk) disable iff (!rstN)
          strobe.shift |=> cellQ[gi+1] == $past(cellQ[gi])); // R6
      end else if (DN_RISE) begin : g_rise_rise
        AST_RISE_SHIFT_ONE: assert property (@(posedge clk) disable iff (!rstN)
          strobe.shift |=> cellQ[gi+1] == $past(cellQ[gi])); // R2
      end else begin : g_fall_fall
        AST_FALL_SHIFT_ONE: assert property (@(negedge clk) disable iff (!rstN)
          strobe.shift |=> cellQ[gi+1] == $past(cellQ[gi])); // R2
      end
    end
  end

  assign capQ    = cellQ;
  assign scanOut = cellQ[LAST];

endmodule

// File: rtl/mixed_edge_scan_chain.sv
module mixed_edge_scan_chain
  import msc_pkg::*;
#(
  parameter int                N            = 8,
  parameter logic [N-1:0]      POLARITY     = 8'hF0,
  parameter msc_pkg::clkStyleT CLK_STYLE    = msc_pkg::CLK_RTZ,
  parameter bit                STRICT_ORDER = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         scanEn,
  input  logic         scanIn,
  input  logic [N-1:0] dataIn,
  output logic         scanOut,
  output logic [N-1:0] capQ
);

  strobeT strobe;

  msc_ctrl #(
    .N            (N),
    .POLARITY     (POLARITY),
    .CLK_STYLE    (CLK_STYLE),
    .STRICT_ORDER (STRICT_ORDER)
  ) u_ctrl (
    .scanEn (scanEn),
    .strobe (strobe)
  );

  msc_datapath #(
    .N        (N),
    .POLARITY (POLARITY)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .scanIn  (scanIn),
    .dataIn  (dataIn),
    .capQ    (capQ),
    .scanOut (scanOut)
  );

endmodule

// File: tb/mixed_edge_scan_chain_tb.sv
`timescale 1ns/1ps
module mixed_edge_scan_chain_tb;

  localparam int N    = 8;
  localparam int NCFG = 5;
  localparam int CYC  = 200;
  localparam logic [N-1:0] POLS [NCFG] = '{8'hFF, 8'h00, 8'hF0, 8'h0F, 8'h55};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scanEn = 1'b0;
  logic scanIn = 1'b0;
  logic [N-1:0] dataIn = '0;
  logic scanOut [NCFG];
  logic [N-1:0] capQ [NCFG];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic hist [CYC];

  always #4 clk = ~clk;

  mixed_edge_scan_chain #(.N(N), .POLARITY(8'hFF)) u_dut (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .scanIn(scanIn), .dataIn(dataIn),
    .scanOut(scanOut[0]), .capQ(capQ[0]));
  mixed_edge_scan_chain #(.N(N), .POLARITY(8'h00)) u_dutFall (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .scanIn(scanIn), .dataIn(dataIn),
    .scanOut(scanOut[1]), .capQ(capQ[1]));
  mixed_edge_scan_chain #(.N(N), .POLARITY(8'hF0)) u_dutFallRise (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .scanIn(scanIn), .dataIn(dataIn),
    .scanOut(scanOut[2]), .capQ(capQ[2]));
  mixed_edge_scan_chain #(.N(N), .POLARITY(8'h0F), .CLK_STYLE(msc_pkg::CLK_NRZ)) u_dutRiseFall (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .scanIn(scanIn), .dataIn(dataIn),
    .scanOut(scanOut[3]), .capQ(capQ[3]));
  mixed_edge_scan_chain #(.N(N), .POLARITY(8'h55)) u_dutAlt (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .scanIn(scanIn), .dataIn(dataIn),
    .scanOut(scanOut[4]), .capQ(capQ[4]));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Half-period count from the R7 rule, in whole periods.
  function automatic int cellLatency(input logic [N-1:0] pol, input int j);
    int d;
    d = pol[0] ? 2 : 1;
    for (int k = 1; k <= j; k++) begin
      if (pol[k-1] && !pol[k])      d += 3;
      else if (!pol[k-1] && pol[k]) d += 1;
      else                          d += 2;
    end
    return (d + 1) / 2;
  endfunction

  task automatic testReset();
    rstN = 1'b0; scanEn = 1'b1; scanIn = 1'b1; dataIn = 8'hFF;
    repeat (3) @(posedge clk);
    #3;
    for (int c = 0; c < NCFG; c++) begin
      check(capQ[c] == '0, "R4", $sformatf("reset capQ cfg%0d", c), capQ[c], 0);
      check(scanOut[c] == 1'b0, "R4", $sformatf("reset scanOut cfg%0d", c), scanOut[c], 0);
    end
    @(posedge clk); #1; rstN = 1'b1;
  endtask

  task automatic testLoad(input logic [N-1:0] val);
    @(posedge clk); #1;
    scanEn = 1'b0; dataIn = val; scanIn = ~val[0];
    @(posedge clk); #2;
    for (int c = 0; c < NCFG; c++) begin
      check(capQ[c] == val, "R3", $sformatf("load capQ cfg%0d", c), capQ[c], val);
      check(scanOut[c] == val[N-1], "R3,R1", $sformatf("load scanOut cfg%0d", c), scanOut[c], val[N-1]);
    end
  endtask

  task automatic testShift();
    logic [15:0] lfsr = 16'hACE1;
    int cellErr [NCFG];
    int outErr [NCFG];
    int uniErr [NCFG];
    for (int c = 0; c < NCFG; c++) begin
      cellErr[c] = 0; outErr[c] = 0; uniErr[c] = 0;
    end
    for (int k = 0; k < CYC; k++) begin
      @(posedge clk); #1;
      scanEn = 1'b1;
      scanIn = lfsr[0];
      hist[k] = lfsr[0];
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
      #2;
      for (int c = 0; c < NCFG; c++) begin
        for (int j = 0; j < N; j++) begin
          int lat = cellLatency(POLS[c], j);
          if (k >= lat && capQ[c][j] !== hist[k-lat]) cellErr[c]++;
        end
        if (k >= cellLatency(POLS[c], N - 1) &&
            scanOut[c] !== hist[k-cellLatency(POLS[c], N - 1)]) outErr[c]++;
        if (c < 2 && k >= N && scanOut[c] !== hist[k-N]) uniErr[c]++;
      end
    end
    for (int c = 0; c < NCFG; c++) begin
      check(cellErr[c] == 0, "R2", $sformatf("per-cell one step per period cfg%0d", c), cellErr[c], 0);
    end
    check(uniErr[0] == 0, "R8", "all-rise latency N", uniErr[0], 0);
    check(uniErr[1] == 0, "R8", "all-fall latency N", uniErr[1], 0);
    check(outErr[2] == 0, "R6,R7", "fall-then-rise scanOut latency", outErr[2], 0);
    check(outErr[3] == 0, "R5,R7", "rise-then-fall scanOut latency", outErr[3], 0);
    check(outErr[4] == 0, "R5,R7", "alternating scanOut latency", outErr[4], 0);
    check(outErr[0] == 0 && outErr[1] == 0, "R7,R1", "uniform scanOut latency", outErr[0] + outErr[1], 0);
  endtask

  task automatic testMidReset();
    @(posedge clk); #2;
    rstN = 1'b0;
    #1;
    for (int c = 0; c < NCFG; c++) begin
      check(capQ[c] == '0, "R4", $sformatf("async clear capQ cfg%0d", c), capQ[c], 0);
    end
    @(posedge clk); #1; rstN = 1'b1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    testReset();
    testLoad(8'hA5);
    testLoad(8'h3C);
    testShift();
    testMidReset();
    finishRun();
  end

  initial begin
    #(8 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog run did not complete actual=1 expected=0");
    finishRun();
  end

endmodule